// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small bank of memory-mapped registers that sits on a simple peripheral bus with a word address, separate read and write strobes, and 32-bit data. It watches the DMA request lines of five on-board peripherals (floppy, printer, network receive, audio play and audio record). It brings them into the bus clock domain and shows their live level in a status register. Through a software-written enable mask it also folds them into one interrupt line.

The same bank drives a handful of board-level controls: a 2-bit selector for the memory clock oscillator, an enable for the flash-programming high-voltage generator, a switch that joins the external display-data-channel pins to the internal bus, and an active-low reset for the disk drive ports. The drive reset bit reads back the real level of the reset pin and not the stored value, so software can spot a pin that is held low. The ROM selection straps, the ROM write-protect state and the memory-module timing IDs are passed through as read-only fields.

Registers sit at word offsets: 0 request status, 1 ROM status, 2 request interrupt enable, 3 clock and system control, 4 memory timing ID. A read strobe loads the addressed register into a read-data holding register. That value appears on the bus one cycle after the strobe.

Top module: `brd_ctl_regs`

## Requirements
- R1: A read of offset 0 returns the request lines after two-flop synchronisation: bit 0 floppy, bit 1 printer, bit 2 network receive, bit 3 audio play, bit 4 audio record, bits 31:5 zero.
- R2: Offset 2 is the request interrupt enable, read/write in bits 4:0 with the same bit layout. It holds 0x00000001 after reset, and bits 31:5 read 0 whatever was written.
- R3: `irq` is 1 exactly when some request bit is both active (as synchronised) and enabled. It follows an input change within two clock edges.
- R4: Bits 1:0 of offset 3 drive `mclk_sel` (00=56 MHz, 01=64 MHz, 10=72 MHz, 11=80 MHz) from the clock edge of the write, and read back as written.
- R5: Bit 2 of offset 3 drives `flash_hv_en` and reads back as written.
- R6: Bit 3 of offset 3 drives `ext_ddc_en` (1 joins the external pins, 0 isolates them) and reads back as written.
- R7: Writing 0 to bit 4 of offset 3 drives `drv_rst_n` low and writing 1 drives it high. A read of bit 4 returns the level of `drv_rst_pin`, which is 0 when the pin is held low elsewhere.
- R8: After reset, offset 3 bits 3:0 are 0 and the stored bit 4 is 1 (`drv_rst_n` high). Bits 31:5 read 0.
- R9: Offset 1 returns `rom_strap` in bits 2:0 (bit 2 is the global ROM write enable) and `rom_wr_open` in bit 3 (1 = ROM space writable), with the other bits 0. Writes to it change nothing.
- R10: Offset 4 returns `bank0_tid` in bits 9:8 and `bank1_tid` in bits 11:10, with all other bits 0.
- R11: Offsets 5 to 7 read as 0. Writes to offsets 0, 1, 4 and 5 to 7 leave the enable and control registers unchanged.
- R12: `bus_rdata` updates on the edge after a cycle with `bus_rd` high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| dma_req_in | input | 5 | Asynchronous DMA request lines (floppy, printer, network, play, record) |
| rom_strap | input | 3 | ROM select straps |
| rom_wr_open | input | 1 | 1 when ROM space is write-unprotected |
| bank0_tid | input | 2 | Memory bank 0 timing ID |
| bank1_tid | input | 2 | Memory bank 1 timing ID |
| drv_rst_pin | input | 1 | Sensed level of the drive reset pin |
| irq | output | 1 | Interrupt from enabled active requests |
| mclk_sel | output | 2 | Memory clock oscillator select |
| flash_hv_en | output | 1 | Flash high-voltage generator enable |
| ext_ddc_en | output | 1 | External display-data-channel mux enable |
| drv_rst_n | output | 1 | Drive reset, active low |

## Verification
The interrupt property assumes that a request line that is low over three sampled edges has passed its low level through the synchronisers. This holds because the bench changes requests only on falling clock edges. The read-back properties take the straps, timing IDs and `drv_rst_pin` as sampled on the strobe edge, so the bench changes those inputs only away from rising edges and holds them across each read. The bench models the reset pin as `drv_rst_n` pulled low by an optional external hold, and it never issues a read and a write in the same cycle.

// File: rtl/brd_ctl_pkg.sv
// Package: shared register offsets, bit positions and reset values of the
// board control register bank. Offsets are word indices on the bus.
package brd_ctl_pkg;

    localparam int OFS_REQ_STAT = 0;
    localparam int OFS_ROM_STAT = 1;
    localparam int OFS_REQ_EN   = 2;
    localparam int OFS_SYS_CTRL = 3;
    localparam int OFS_MEM_TID  = 4;
    localparam int OFS_LAST     = OFS_MEM_TID;

    localparam int MCLK_W     = 2;
    localparam int CTL_HV_BIT = 2;
    localparam int CTL_DDC_BIT = 3;
    localparam int CTL_RST_BIT = 4;
    localparam int CTL_W      = CTL_RST_BIT + 1;

    localparam int ROM_OPEN_BIT = 3;
    localparam int TID0_LSB     = 8;
    localparam int TID1_LSB     = 10;

    // Stored control fields; the order matches the control register bits.
    typedef struct packed {
        logic              drv_rst_n;
        logic              ddc_en;
        logic              hv_en;
        logic [MCLK_W-1:0] mclk;
    } sys_ctrl_t;

    localparam sys_ctrl_t SYS_CTRL_RST = '{drv_rst_n: 1'b1, ddc_en: 1'b0,
                                           hv_en: 1'b0, mclk: '0};

endpackage

// File: rtl/brd_req_sync.sv
// Module: brd_req_sync
// Brings a vector of asynchronous level signals into the clk domain with an
// independent flip-flop chain per bit. Assumes STAGES >= 2 and that each bit
// is a slow level, so per-bit skew of one cycle is acceptable.
module brd_req_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw input through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], d_async[b]};
                end
            end

            assign q_sync[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/brd_irq_mask.sv
// Module: brd_irq_mask
// Holds the request interrupt enable mask and combines it with the
// synchronised request levels into one interrupt. Assumes req_sync already
// comes from flip-flops in the clk domain.
module brd_irq_mask #(
    parameter int              NREQ   = 5,
    parameter logic [NREQ-1:0] EN_RST = NREQ'(1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NREQ-1:0] wdata,
    input  logic [NREQ-1:0] req_sync,
    output logic [NREQ-1:0] en_q,
    output logic            irq
);

    // Load the enable mask on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= EN_RST;
        end else if (wr_en) begin
            en_q <= wdata;
        end
    end

    // Any enabled, active request raises the interrupt.
    always_comb begin
        irq = |(req_sync & en_q);
    end

endmodule

// File: rtl/brd_sys_ctrl.sv
// Module: brd_sys_ctrl
// Stores the clock and system control fields and drives the board outputs
// straight from the stored bits. Assumes wdata carries register bits
// CTL_W-1:0 unmodified.
module brd_sys_ctrl
    import brd_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [CTL_W-1:0] wdata,
    output sys_ctrl_t        ctrl_q
);

    sys_ctrl_t ctrl_d;

    // Map the written bits onto the control fields.
    always_comb begin
        ctrl_d.mclk      = wdata[MCLK_W-1:0];
        ctrl_d.hv_en     = wdata[CTL_HV_BIT];
        ctrl_d.ddc_en    = wdata[CTL_DDC_BIT];
        ctrl_d.drv_rst_n = wdata[CTL_RST_BIT];
    end

    // Hold the control fields; reset releases the drive reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= SYS_CTRL_RST;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/brd_rd_mux.sv
// Module: brd_rd_mux
// Selects the addressed register image and loads it into the read-data
// holding register when the read strobe is high. Assumes DATA_W is wide
// enough for the timing ID field (at least 12 bits).
module brd_rd_mux
    import brd_ctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int NREQ    = 5,
    parameter int STRAP_W = 3,
    parameter int TID_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NREQ-1:0]    req_sync,
    input  logic [NREQ-1:0]    en_q,
    input  sys_ctrl_t          ctrl_q,
    input  logic               rst_pin,
    input  logic [STRAP_W-1:0] rom_strap,
    input  logic               rom_wr_open,
    input  logic [TID_W-1:0]   tid0,
    input  logic [TID_W-1:0]   tid1,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] img;
    sys_ctrl_t         ctrl_view;

    // Control image: stored fields, but the reset bit shows the pin level.
    always_comb begin
        ctrl_view           = ctrl_q;
        ctrl_view.drv_rst_n = rst_pin;
    end

    // Build the image of the addressed register; unmapped offsets give 0.
    always_comb begin
        img = '0;
        case (addr)
            ADDR_W'(OFS_REQ_STAT): img[NREQ-1:0] = req_sync;
            ADDR_W'(OFS_ROM_STAT): begin
                img[STRAP_W-1:0]  = rom_strap;
                img[ROM_OPEN_BIT] = rom_wr_open;
            end
            ADDR_W'(OFS_REQ_EN):   img[NREQ-1:0] = en_q;
            ADDR_W'(OFS_SYS_CTRL): img[CTL_W-1:0] = ctrl_view;
            ADDR_W'(OFS_MEM_TID): begin
                img[TID0_LSB +: TID_W] = tid0;
                img[TID1_LSB +: TID_W] = tid1;
            end
            default: img = '0;
        endcase
    end

    // Capture the image on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= img;
        end
    end

endmodule

// File: rtl/brd_ctl_regs.sv
// Module: brd_ctl_regs (top)
// Board control register bank: DMA request status and interrupt masking,
// clock and system control outputs, and read-only strap and timing ID
// fields on a simple word-addressed register bus. Assumes one strobe per
// cycle at most and that the strobes come from the clk domain.
module brd_ctl_regs
    import brd_ctl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3,
    parameter int NREQ        = 5,
    parameter int SYNC_STAGES = 2,
    parameter int STRAP_W     = 3,
    parameter int TID_W       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NREQ-1:0]    dma_req_in,
    input  logic [STRAP_W-1:0] rom_strap,
    input  logic               rom_wr_open,
    input  logic [TID_W-1:0]   bank0_tid,
    input  logic [TID_W-1:0]   bank1_tid,
    input  logic               drv_rst_pin,
    output logic               irq,
    output logic [MCLK_W-1:0]  mclk_sel,
    output logic               flash_hv_en,
    output logic               ext_ddc_en,
    output logic               drv_rst_n
);

    localparam int WIDE_W = (NREQ > CTL_W) ? NREQ : CTL_W;

    logic [NREQ-1:0] req_sync;
    logic [NREQ-1:0] en_q;
    logic            wr_en;
    logic            wr_ctrl;
    sys_ctrl_t       ctrl_q;
    logic            unused_wdata_hi;

    // Decode register writes from the word offset.
    always_comb begin
        wr_en   = bus_wr && (bus_addr == ADDR_W'(OFS_REQ_EN));
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_SYS_CTRL));
    end

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WIDE_W];

    brd_req_sync #(
        .WIDTH  (NREQ),
        .STAGES (SYNC_STAGES)
    ) i_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (dma_req_in),
        .q_sync  (req_sync)
    );

    brd_irq_mask #(
        .NREQ   (NREQ),
        .EN_RST (NREQ'(1))
    ) i_irq_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wdata    (bus_wdata[NREQ-1:0]),
        .req_sync (req_sync),
        .en_q     (en_q),
        .irq      (irq)
    );

    brd_sys_ctrl i_sys_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata[CTL_W-1:0]),
        .ctrl_q  (ctrl_q)
    );

    brd_rd_mux #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NREQ    (NREQ),
        .STRAP_W (STRAP_W),
        .TID_W   (TID_W)
    ) i_rd_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd          (bus_rd),
        .addr        (bus_addr),
        .req_sync    (req_sync),
        .en_q        (en_q),
        .ctrl_q      (ctrl_q),
        .rst_pin     (drv_rst_pin),
        .rom_strap   (rom_strap),
        .rom_wr_open (rom_wr_open),
        .tid0        (bank0_tid),
        .tid1        (bank1_tid),
        .rdata       (bus_rdata)
    );

    // Drive the board control outputs from the stored fields.
    always_comb begin
        mclk_sel    = ctrl_q.mclk;
        flash_hv_en = ctrl_q.hv_en;
        ext_ddc_en  = ctrl_q.ddc_en;
        drv_rst_n   = ctrl_q.drv_rst_n;
    end

endmodule

// File: rtl/brd_ctl_regs_chk.sv
// Module: brd_ctl_regs_chk
// Port-level temporal checks of the board control register bank, attached
// to every instance of the top module by the bind below.
module brd_ctl_regs_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int NREQ    = 5,
    parameter int STRAP_W = 3,
    parameter int TID_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [4:0]         wr_lo,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NREQ-1:0]    dma_req_in,
    input logic [STRAP_W-1:0] rom_strap,
    input logic               rom_wr_open,
    input logic [TID_W-1:0]   bank0_tid,
    input logic [TID_W-1:0]   bank1_tid,
    input logic               drv_rst_pin,
    input logic               irq,
    input logic [1:0]         mclk_sel,
    input logic               flash_hv_en,
    input logic               ext_ddc_en,
    input logic               drv_rst_n
);

    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(3));

    p_quiet_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_in == '0 && $past(dma_req_in) == '0 && $past(dma_req_in, 2) == '0) |-> !irq);

    p_mclk_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> mclk_sel == $past(wr_lo[1:0]));

    p_hv_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> flash_hv_en == $past(wr_lo[2]));

    p_ddc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ext_ddc_en == $past(wr_lo[3]));

    p_rst_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> drv_rst_n == $past(wr_lo[4]));

    p_pin_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(3)) |=> bus_rdata[4] == $past(drv_rst_pin));

    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable({mclk_sel, flash_hv_en, ext_ddc_en, drv_rst_n}));

    p_rom_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(1)) |=>
        bus_rdata == DATA_W'({$past(rom_wr_open), $past(rom_strap)}));

    p_tid_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(4)) |=>
        bus_rdata == (DATA_W'({$past(bank1_tid), $past(bank0_tid)}) << 8));

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > ADDR_W'(4)) |=> bus_rdata == '0);

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NREQ    (NREQ),
    .STRAP_W (STRAP_W),
    .TID_W   (TID_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .wr_lo       (bus_wdata[4:0]),
    .bus_rdata   (bus_rdata),
    .dma_req_in  (dma_req_in),
    .rom_strap   (rom_strap),
    .rom_wr_open (rom_wr_open),
    .bank0_tid   (bank0_tid),
    .bank1_tid   (bank1_tid),
    .drv_rst_pin (drv_rst_pin),
    .irq         (irq),
    .mclk_sel    (mclk_sel),
    .flash_hv_en (flash_hv_en),
    .ext_ddc_en  (ext_ddc_en),
    .drv_rst_n   (drv_rst_n)
);

// File: tb/test_brd_ctl_regs.sv
// Bench for brd_ctl_regs: sweeps all request/enable pairs, all control
// values with and without an external reset hold, all strap and ID values.
module test_brd_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  dma_req_in = '0;
    logic [2:0]  rom_strap = '0;
    logic        rom_wr_open = 1'b0;
    logic [1:0]  bank0_tid = '0;
    logic [1:0]  bank1_tid = '0;
    logic        ext_hold = 1'b0;
    logic        drv_rst_pin;
    logic        irq;
    logic [1:0]  mclk_sel;
    logic        flash_hv_en;
    logic        ext_ddc_en;
    logic        drv_rst_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    assign drv_rst_pin = drv_rst_n & ~ext_hold;

    always #4 clk = ~clk;

    brd_ctl_regs i_brd_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_req_in(dma_req_in), .rom_strap(rom_strap),
        .rom_wr_open(rom_wr_open), .bank0_tid(bank0_tid),
        .bank1_tid(bank1_tid), .drv_rst_pin(drv_rst_pin), .irq(irq),
        .mclk_sel(mclk_sel), .flash_hv_en(flash_hv_en),
        .ext_ddc_en(ext_ddc_en), .drv_rst_n(drv_rst_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: act=0x%08h exp=0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog: act=0x%08h exp=0x%08h", cycles, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] ctrl_save;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        bus_read(3'd2, rd);
        chk("R2", "enable after reset", rd, 32'h1);
        bus_read(3'd3, rd);
        chk("R8", "control after reset", rd, 32'h10);
        chk("R8", "outputs after reset",
            {28'd0, drv_rst_n, ext_ddc_en, flash_hv_en, mclk_sel},
            {28'd0, 1'b1, 1'b0, 1'b0, 2'b00});
        chk("R3", "irq idle after reset", {31'd0, irq}, 32'd0);
        bus_read(3'd0, rd);
        chk("R1", "status after reset", rd, 32'd0);

        // Enable register width and read/write
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read(3'd2, rd);
        chk("R2", "enable upper bits ignored", rd, 32'h1F);

        // Exhaustive request x enable sweep
        for (int en = 0; en < 32; en++) begin
            bus_write(3'd2, 32'(en) | 32'hA5A5_A5A0);
            bus_read(3'd2, rd);
            chk("R2", "enable readback", rd, 32'(en));
            for (int rq = 0; rq < 32; rq++) begin
                dma_req_in = 5'(rq);
                repeat (3) @(negedge clk);
                chk("R3", "irq", {31'd0, irq}, {31'd0, |(5'(rq) & 5'(en))});
                bus_read(3'd0, rd);
                chk("R1", "request status", rd, 32'(rq));
            end
        end
        dma_req_in = '0;

        // Control sweep with and without an external hold on the reset pin
        for (int h = 0; h < 2; h++) begin
            ext_hold = h[0];
            for (int v = 0; v < 32; v++) begin
                bus_write(3'd3, 32'(v) | 32'h5A5A_5A40);
                chk("R4", "mclk_sel", {30'd0, mclk_sel}, {30'd0, 2'(v)});
                chk("R5", "flash_hv_en", {31'd0, flash_hv_en}, {31'd0, v[2]});
                chk("R6", "ext_ddc_en", {31'd0, ext_ddc_en}, {31'd0, v[3]});
                chk("R7", "drv_rst_n", {31'd0, drv_rst_n}, {31'd0, v[4]});
                bus_read(3'd3, rd);
                chk("R7", "control readback with pin level", rd,
                    {27'd0, v[4] & ~h[0], v[3], v[2], v[1], v[0]});
            end
        end
        ext_hold = 1'b0;

        // ROM status sweep, writes ignored
        for (int s = 0; s < 16; s++) begin
            rom_strap = 3'(s);
            rom_wr_open = s[3];
            bus_write(3'd1, 32'hFFFF_FFFF);
            bus_read(3'd1, rd);
            chk("R9", "rom status", rd, 32'(s));
        end

        // Timing ID sweep
        for (int t = 0; t < 16; t++) begin
            bank0_tid = 2'(t);
            bank1_tid = 2'(t >> 2);
            bus_read(3'd4, rd);
            chk("R10", "timing id", rd, 32'(t) << 8);
        end

        // Unmapped and read-only writes leave registers alone
        bus_write(3'd2, 32'h0000_0015);
        bus_write(3'd3, 32'h0000_0016);
        bus_read(3'd3, ctrl_save);
        for (int a = 5; a < 8; a++) begin
            bus_read(3'(a), rd);
            chk("R11", "unmapped read", rd, 32'd0);
        end
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_write(3'd4, 32'hFFFF_FFFF);
        for (int a = 5; a < 8; a++) bus_write(3'(a), 32'hFFFF_FFFF);
        bus_read(3'd2, rd);
        chk("R11", "enable after stray writes", rd, 32'h15);
        bus_read(3'd3, rd);
        chk("R11", "control after stray writes", rd, ctrl_save);
        chk("R11", "outputs after stray writes",
            {28'd0, drv_rst_n, ext_ddc_en, flash_hv_en, mclk_sel}, 32'h16);

        // Read data holds without a strobe
        bank0_tid = 2'd1; bank1_tid = 2'd2;
        bus_read(3'd4, rd);
        chk("R12", "read before hold", rd, 32'h0000_0900);
        bank0_tid = 2'd3; bank1_tid = 2'd3;
        bus_addr = 3'd0;
        repeat (4) @(negedge clk);
        chk("R12", "read data held", bus_rdata, 32'h0000_0900);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule